// File: doc/BRIEF.md
# Packetized PIO Data Port with Event Status

This block sits between a 32-bit host register bus and the byte-wide data phase of a NAND flash bus. A sequencer starts a transfer with a one-cycle pulse and a direction bit. The block then moves the transfer as a programmed number of equal packets through a one-packet buffer. The host reaches that buffer through a single data-port register, one dword per access. Before each packet the block raises a direction-specific ready event, and after the last packet it raises a completion event.

Events latch into a write-one-to-clear status register. Two masks act on them. The status-enable mask decides which events may latch at all. The signal-enable mask decides which latched events drive the interrupt output. Software can therefore poll the status with the interrupt left off, which is the reset arrangement.

Register word addresses on `reg_addr` are: 0 for the packet setup, 1 for the data port, 2 for the event status, 3 for the status enable and 4 for the signal enable. A register read returns its data on `reg_rdata` in the cycle after `reg_rd_en`.

Top module: `pio_data_port`

## Requirements
- R1: After reset the packet setup reads 0, the event status reads 0, the status enable reads 0xFF, the signal enable reads 0, `irq` is low, and a data-port read returns 0.
- R2: The packet setup register holds the packet size in bytes in bits 10:0 and the packet count in bits 23:12. All other bits read back as zero.
- R3: A packet's bus length is its size rounded up to a multiple of four bytes. A read packet of size 6 becomes ready only after 8 bytes, and a write packet of size 5 sends 8 bytes.
- R4: In the NAND-to-host direction, the read-ready event (status bit 1) sets once a whole packet is in the buffer. Each data-port read then returns the next dword, with the first bus byte in bits 7:0.
- R5: In the host-to-NAND direction, the write-ready event (status bit 0) sets before each packet. Once the packet's dwords have been written, its bytes go out least significant byte first, and the data holds steady while the receiver stalls.
- R6: The transfer-complete event (status bit 2) sets after the final packet. A start with a count of 0 or a size of 0 sets it at once and moves no data.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R8: An event whose status-enable bit is 0 does not latch.
- R9: `irq` is high exactly when a latched status bit has its signal-enable bit set, and it follows one cycle behind the status.
- R10: A data-port read while no packet is waiting returns 0 and does not advance the read position. A data-port write while the block is not collecting a write packet is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle start pulse from the sequencer |
| xfer_dir_rd | input | 1 | 1 = NAND to host, 0 = host to NAND; sampled with the start pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the read strobe |
| nand_rx_valid | input | 1 | Byte from the NAND bus is valid |
| nand_rx_data | input | 8 | Byte from the NAND bus |
| nand_rx_ready | output | 1 | Block accepts a byte from the NAND bus |
| nand_tx_valid | output | 1 | Byte for the NAND bus is valid |
| nand_tx_data | output | 8 | Byte for the NAND bus |
| nand_tx_ready | input | 1 | NAND bus accepts the byte |
| irq | output | 1 | Interrupt output |

## Verification
The bench targets three corner cases. A size that is not a multiple of four must stretch the packet to the next dword. A design that used the raw size would flag a read packet ready after 6 bytes, or send only 5 bytes for a write packet. Data-port reads made before a packet is ready, or after it has drained, must return zero without moving the read position; a design that advanced the position would skip the first dword of the next packet. The bench also checks that a write arriving while a packet is being sent adds no bytes to the bus stream. Mask handling gets its own runs: completion is masked from latching, the interrupt is enabled on a single bit, and that bit is cleared again. A design that mixed up the two masks would either latch a masked event or raise `irq` from a bit whose signal enable is off.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Register word addresses
  localparam logic [2:0] RA_PKT   = 3'd0;
  localparam logic [2:0] RA_DATA  = 3'd1;
  localparam logic [2:0] RA_STAT  = 3'd2;
  localparam logic [2:0] RA_STEN  = 3'd3;
  localparam logic [2:0] RA_SIGEN = 3'd4;

  // Event bit positions
  localparam int unsigned EV_WR_RDY = 0;
  localparam int unsigned EV_RD_RDY = 1;
  localparam int unsigned EV_DONE   = 2;

  // Field placement inside the packet setup word
  localparam int unsigned PKT_CNT_LSB = 12;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_LOAD  = 3'd3,
    ST_SEND  = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/pio_pkt_buf.sv
module pio_pkt_buf #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pio_evt_status.sv
module pio_evt_status
  import pio_pkg::*;
#(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [EVT_W-1:0] wdata,
  input  logic [EVT_W-1:0] ev,
  output logic [EVT_W-1:0] status,
  output logic [EVT_W-1:0] sten,
  output logic [EVT_W-1:0] sigen,
  output logic             irq
);
  logic [EVT_W-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (wr_en && addr == RA_STAT) clr_mask = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      sten   <= '1;
      sigen  <= '0;
      irq    <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      status <= (status & ~clr_mask) | (ev & sten);
      if (wr_en && addr == RA_STEN)  sten  <= wdata;
      if (wr_en && addr == RA_SIGEN) sigen <= wdata;
      irq <= |(status & sigen);
    end
  end
endmodule

// File: rtl/pio_xfer_ctrl.sv
module pio_xfer_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned SIZE_W = 11,
  parameter int unsigned CNT_W  = 12,
  localparam int unsigned WORDS_W = SIZE_W - 1,
  localparam int unsigned PTR_W   = SIZE_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_rd,
  input  logic [SIZE_W-1:0] pkt_size,
  input  logic [CNT_W-1:0]  pkt_count,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  input  logic              host_rd,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic [31:0]       mem_q,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_waddr,
  output logic [31:0]       mem_wdata,
  output logic [PTR_W-1:0]  mem_raddr,
  output logic              dp_avail,
  output logic              ev_wr_rdy,
  output logic              ev_rd_rdy,
  output logic              ev_done
);
  xfer_state_e        state;
  logic [WORDS_W-1:0] words_q, wptr, rptr;
  logic [CNT_W-1:0]   cnt_q, pidx;
  logic [1:0]         bcnt, tbc;
  logic [23:0]        acc;
  logic [31:0]        tx_word;
  logic               tx_have, fetch_pend;

  logic [WORDS_W-1:0] words_n, words_last;
  logic               xfer_zero, pkt_last, rx_fire, word_in, send_done;

  // packet length in dwords, rounded up
  assign words_n    = {1'b0, pkt_size[SIZE_W-1:2]} + WORDS_W'(|pkt_size[1:0]);
  assign words_last = words_q - WORDS_W'(1);
  assign xfer_zero  = (words_n == '0) || (pkt_count == '0);
  assign pkt_last   = (pidx == cnt_q - CNT_W'(1));

  assign rx_ready  = (state == ST_FILL);
  assign rx_fire   = rx_valid && rx_ready;
  assign word_in   = rx_fire && (bcnt == 2'd3);
  assign tx_valid  = tx_have;
  assign tx_data   = tx_word[7:0];
  assign send_done = (state == ST_SEND) && tx_have && tx_ready &&
                     (tbc == 2'd3) && (rptr == words_last);
  assign dp_avail  = (state == ST_DRAIN);

  assign mem_we    = ((state == ST_FILL) && word_in) || ((state == ST_LOAD) && host_wr);
  assign mem_waddr = wptr[PTR_W-1:0];
  assign mem_wdata = (state == ST_LOAD) ? host_wdata : {rx_data, acc};
  assign mem_raddr = rptr[PTR_W-1:0];

  assign ev_rd_rdy = (state == ST_FILL) && word_in && (wptr == words_last);
  assign ev_wr_rdy = ((state == ST_IDLE) && start && !dir_rd && !xfer_zero) ||
                     (send_done && !pkt_last);
  assign ev_done   = ((state == ST_IDLE) && start && xfer_zero) ||
                     ((state == ST_DRAIN) && host_rd && (rptr == words_last) && pkt_last) ||
                     (send_done && pkt_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      words_q    <= '0;
      cnt_q      <= '0;
      pidx       <= '0;
      wptr       <= '0;
      rptr       <= '0;
      bcnt       <= '0;
      tbc        <= '0;
      acc        <= '0;
      tx_word    <= '0;
      tx_have    <= 1'b0;
      fetch_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            words_q <= words_n;
            cnt_q   <= pkt_count;
            pidx    <= '0;
            wptr    <= '0;
            rptr    <= '0;
            bcnt    <= '0;
            if (!xfer_zero) state <= dir_rd ? ST_FILL : ST_LOAD;
          end
        end
        ST_FILL: begin
          if (rx_fire) begin
            acc  <= {rx_data, acc[23:8]};
            bcnt <= bcnt + 2'd1;
            if (word_in) begin
              wptr <= wptr + WORDS_W'(1);
              if (wptr == words_last) begin
                state <= ST_DRAIN;
                rptr  <= '0;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (host_rd) begin
            rptr <= rptr + WORDS_W'(1);
            if (rptr == words_last) begin
              if (pkt_last) begin
                state <= ST_IDLE;
              end else begin
                pidx  <= pidx + CNT_W'(1);
                wptr  <= '0;
                bcnt  <= '0;
                state <= ST_FILL;
              end
            end
          end
        end
        ST_LOAD: begin
          if (host_wr) begin
            wptr <= wptr + WORDS_W'(1);
            if (wptr == words_last) begin
              state      <= ST_SEND;
              rptr       <= '0;
              tx_have    <= 1'b0;
              fetch_pend <= 1'b0;
            end
          end
        end
        ST_SEND: begin
          if (fetch_pend) begin
            tx_word    <= mem_q;
            tx_have    <= 1'b1;
            fetch_pend <= 1'b0;
            tbc        <= '0;
          end else if (!tx_have) begin
            fetch_pend <= 1'b1;
          end else if (tx_ready) begin
            tx_word <= {8'h00, tx_word[31:8]};
            tbc     <= tbc + 2'd1;
            if (tbc == 2'd3) begin
              tx_have <= 1'b0;
              rptr    <= rptr + WORDS_W'(1);
              if (rptr == words_last) begin
                if (pkt_last) begin
                  state <= ST_IDLE;
                end else begin
                  pidx  <= pidx + CNT_W'(1);
                  wptr  <= '0;
                  state <= ST_LOAD;
                end
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_data_port.sv
module pio_data_port
  import pio_pkg::*;
#(
  parameter int unsigned SIZE_W = 11,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned EVT_W  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        xfer_start,
  input  logic        xfer_dir_rd,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        nand_rx_valid,
  input  logic [7:0]  nand_rx_data,
  output logic        nand_rx_ready,
  output logic        nand_tx_valid,
  output logic [7:0]  nand_tx_data,
  input  logic        nand_tx_ready,
  output logic        irq
);
  localparam int unsigned PTR_W = SIZE_W - 2;

  logic [SIZE_W-1:0] pkt_size_q;
  logic [CNT_W-1:0]  pkt_cnt_q;
  logic [31:0]       pkt_word;
  logic [EVT_W-1:0]  evt_status, evt_sten, evt_sigen, evt_raw;
  logic              ev_wr_rdy, ev_rd_rdy, ev_done;
  logic              host_wr, host_rd, dp_avail;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_waddr, mem_raddr;
  logic [31:0]       mem_wdata, mem_q;
  logic [31:0]       rd_reg_q;
  logic              rd_is_data_q, dp_valid_q;

  assign host_wr = reg_wr_en && (reg_addr == RA_DATA);
  assign host_rd = reg_rd_en && (reg_addr == RA_DATA);

  always_comb begin
    pkt_word = '0;
    pkt_word[SIZE_W-1:0] = pkt_size_q;
    pkt_word[PKT_CNT_LSB +: CNT_W] = pkt_cnt_q;
  end

  always_comb begin
    evt_raw = '0;
    evt_raw[EV_WR_RDY] = ev_wr_rdy;
    evt_raw[EV_RD_RDY] = ev_rd_rdy;
    evt_raw[EV_DONE]   = ev_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_size_q   <= '0;
      pkt_cnt_q    <= '0;
      rd_reg_q     <= '0;
      rd_is_data_q <= 1'b0;
      dp_valid_q   <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == RA_PKT) begin
        pkt_size_q <= reg_wdata[SIZE_W-1:0];
        pkt_cnt_q  <= reg_wdata[PKT_CNT_LSB +: CNT_W];
      end
      rd_is_data_q <= host_rd;
      dp_valid_q   <= dp_avail;
      unique case (reg_addr)
        RA_PKT:   rd_reg_q <= pkt_word;
        RA_STAT:  rd_reg_q <= 32'(evt_status);
        RA_STEN:  rd_reg_q <= 32'(evt_sten);
        RA_SIGEN: rd_reg_q <= 32'(evt_sigen);
        default:  rd_reg_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rd_is_data_q ? (dp_valid_q ? mem_q : 32'h0) : rd_reg_q;

  pio_xfer_ctrl #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (xfer_start),
    .dir_rd     (xfer_dir_rd),
    .pkt_size   (pkt_size_q),
    .pkt_count  (pkt_cnt_q),
    .host_wr    (host_wr),
    .host_wdata (reg_wdata),
    .host_rd    (host_rd),
    .rx_valid   (nand_rx_valid),
    .rx_data    (nand_rx_data),
    .rx_ready   (nand_rx_ready),
    .tx_valid   (nand_tx_valid),
    .tx_data    (nand_tx_data),
    .tx_ready   (nand_tx_ready),
    .mem_q      (mem_q),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_raddr  (mem_raddr),
    .dp_avail   (dp_avail),
    .ev_wr_rdy  (ev_wr_rdy),
    .ev_rd_rdy  (ev_rd_rdy),
    .ev_done    (ev_done)
  );

  pio_pkt_buf #(.DATA_W(32), .ADDR_W(PTR_W)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_q)
  );

  pio_evt_status #(.EVT_W(EVT_W)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata[EVT_W-1:0]),
    .ev     (evt_raw),
    .status (evt_status),
    .sten   (evt_sten),
    .sigen  (evt_sigen),
    .irq    (irq)
  );
endmodule

// File: rtl/pio_data_port_chk.sv
module pio_data_port_chk
  import pio_pkg::*;
#(
  parameter int unsigned EVT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [EVT_W-1:0] status,
  input logic [EVT_W-1:0] sten,
  input logic [EVT_W-1:0] sigen,
  input logic [EVT_W-1:0] ev,
  input logic             irq,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rx_ready
);
  // R8
  latch_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status) & ~$past(sten)) == '0));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr_en && reg_addr == RA_STAT) |->
      ((status & $past(reg_wdata[EVT_W-1:0]) & ~$past(ev)) == '0));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(sigen) != '0));

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4
  dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_ready && tx_valid));
endmodule

bind pio_data_port pio_data_port_chk #(.EVT_W(EVT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status    (evt_status),
  .sten      (evt_sten),
  .sigen     (evt_sigen),
  .ev        (evt_raw),
  .irq       (irq),
  .tx_valid  (nand_tx_valid),
  .tx_ready  (nand_tx_ready),
  .tx_data   (nand_tx_data),
  .rx_ready  (nand_rx_ready)
);

// File: tb/pio_data_port_bench.sv
`timescale 1ns/1ps
module pio_data_port_bench;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_start = 1'b0, xfer_dir_rd = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nand_rx_valid = 1'b0;
  logic [7:0]  nand_rx_data = '0;
  logic        nand_rx_ready;
  logic        nand_tx_valid;
  logic [7:0]  nand_tx_data;
  logic        nand_tx_ready = 1'b1;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx_buf [64];
  int tx_n = 0;

  always #4 clk = ~clk;

  pio_data_port u_pio_data_port (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_dir_rd(xfer_dir_rd),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nand_rx_valid(nand_rx_valid), .nand_rx_data(nand_rx_data),
    .nand_rx_ready(nand_rx_ready), .nand_tx_valid(nand_tx_valid),
    .nand_tx_data(nand_tx_data), .nand_tx_ready(nand_tx_ready), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst && nand_tx_valid && nand_tx_ready) begin
      if (tx_n < 64) tx_buf[tx_n] = nand_tx_data;
      tx_n++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic start_xfer(logic rd);
    xfer_start = 1'b1; xfer_dir_rd = rd;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic push_byte(logic [7:0] b);
    nand_rx_valid = 1'b1; nand_rx_data = b;
    while (!nand_rx_ready) @(negedge clk);
    @(negedge clk);
    nand_rx_valid = 1'b0;
  endtask

  task automatic wait_evt(int bitn, string req);
    logic [31:0] v;
    int n = 0;
    do begin
      reg_read(RA_STAT, v);
      n++;
    end while (!v[bitn] && n < 300);
    chk(req, 32'(v[bitn]), 32'd1);
  endtask

  task automatic wait_tx(int target);
    int n = 0;
    while (tx_n < target && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(RA_PKT, v);   chk("R1 pkt reset", v, 32'h0);
    reg_read(RA_STAT, v);  chk("R1 status reset", v, 32'h0);
    reg_read(RA_STEN, v);  chk("R1 status-enable reset", v, 32'hFF);
    reg_read(RA_SIGEN, v); chk("R1 signal-enable reset", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);
    reg_read(RA_DATA, v);  chk("R1 empty data port", v, 32'h0);
  endtask

  task automatic t_pkt_fields();
    logic [31:0] v;
    reg_write(RA_PKT, 32'hFFFF_FFFF);
    reg_read(RA_PKT, v);
    chk("R2 pkt field mask", v, 32'h00FF_F7FF);
    reg_write(RA_PKT, 32'h0000_3123);
    reg_read(RA_PKT, v);
    chk("R2 pkt size/count", v, 32'h0000_3123);
  endtask

  task automatic t_read_xfer();
    logic [31:0] v;
    reg_write(RA_PKT, 32'd8 | (32'd2 << 12));
    start_xfer(1'b1);
    reg_read(RA_DATA, v); chk("R10 read before fill is zero", v, 32'h0);
    for (int i = 0; i < 8; i++) push_byte(8'h11 + 8'(i));
    wait_evt(EV_RD_RDY, "R4 read-ready packet 1");
    reg_read(RA_DATA, v); chk("R4 R10 first dword not skipped", v, 32'h1413_1211);
    reg_read(RA_DATA, v); chk("R4 second dword", v, 32'h1817_1615);
    reg_read(RA_DATA, v); chk("R10 read after drain is zero", v, 32'h0);
    reg_read(RA_STAT, v); chk("R4 only read-ready latched", v, 32'h2);
    reg_write(RA_STAT, 32'h0);
    reg_read(RA_STAT, v); chk("R7 writing zero keeps bit", v, 32'h2);
    reg_write(RA_STAT, 32'h2);
    reg_read(RA_STAT, v); chk("R7 write-one clears", v, 32'h0);
    for (int i = 0; i < 8; i++) push_byte(8'h21 + 8'(i));
    wait_evt(EV_RD_RDY, "R4 read-ready packet 2");
    reg_read(RA_DATA, v); chk("R4 pkt2 dword0", v, 32'h2423_2221);
    reg_read(RA_DATA, v); chk("R4 pkt2 dword1", v, 32'h2827_2625);
    reg_read(RA_STAT, v); chk("R6 complete after final packet", v, 32'h6);
    chk("R9 irq low with signal enable zero", 32'(irq), 32'h0);
    reg_write(RA_STAT, 32'hFF);
  endtask

  task automatic t_round();
    logic [31:0] v;
    reg_write(RA_PKT, 32'd6 | (32'd1 << 12));
    start_xfer(1'b1);
    for (int i = 0; i < 6; i++) push_byte(8'h31 + 8'(i));
    repeat (3) @(negedge clk);
    reg_read(RA_STAT, v); chk("R3 not ready after 6 bytes", v, 32'h0);
    push_byte(8'h37);
    push_byte(8'h38);
    wait_evt(EV_RD_RDY, "R3 ready after 8 bytes");
    reg_read(RA_DATA, v); chk("R3 dword0", v, 32'h3433_3231);
    reg_read(RA_DATA, v); chk("R3 dword1", v, 32'h3837_3635);
    reg_write(RA_STAT, 32'hFF);
    tx_n = 0;
    reg_write(RA_PKT, 32'd5 | (32'd1 << 12));
    start_xfer(1'b0);
    wait_evt(EV_WR_RDY, "R5 write-ready size 5");
    reg_write(RA_DATA, 32'h4342_4140);
    reg_write(RA_DATA, 32'h4746_4544);
    wait_evt(EV_DONE, "R6 size-5 write complete");
    repeat (4) @(negedge clk);
    chk("R3 size 5 sends 8 bytes", 32'(tx_n), 32'd8);
    chk("R3 padded byte 7", 32'(tx_buf[7]), 32'h47);
    reg_write(RA_STAT, 32'hFF);
  endtask

  task automatic t_write_xfer();
    logic [31:0] v;
    tx_n = 0;
    reg_write(RA_PKT, 32'd8 | (32'd2 << 12));
    start_xfer(1'b0);
    wait_evt(EV_WR_RDY, "R5 write-ready packet 1");
    reg_write(RA_STAT, 32'h1);
    reg_write(RA_DATA, 32'hA3A2_A1A0);
    reg_write(RA_DATA, 32'hA7A6_A5A4);
    reg_write(RA_DATA, 32'hDEAD_BEEF);
    wait_tx(8);
    wait_evt(EV_WR_RDY, "R5 write-ready packet 2");
    for (int i = 0; i < 8; i++)
      chk("R5 packet 1 byte order", 32'(tx_buf[i]), 32'hA0 + 32'(i));
    reg_write(RA_DATA, 32'hB3B2_B1B0);
    reg_write(RA_DATA, 32'hB7B6_B5B4);
    wait_evt(EV_DONE, "R6 write complete");
    repeat (4) @(negedge clk);
    chk("R10 dropped write adds no bytes", 32'(tx_n), 32'd16);
    for (int i = 0; i < 8; i++)
      chk("R5 packet 2 byte order", 32'(tx_buf[8 + i]), 32'hB0 + 32'(i));
    reg_write(RA_STAT, 32'hFF);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    reg_write(RA_STEN, 32'h3);
    reg_write(RA_SIGEN, 32'h4);
    reg_write(RA_PKT, 32'd4 | (32'd1 << 12));
    start_xfer(1'b1);
    for (int i = 0; i < 4; i++) push_byte(8'h51 + 8'(i));
    wait_evt(EV_RD_RDY, "R8 enabled event latches");
    reg_read(RA_DATA, v); chk("R4 single dword", v, 32'h5453_5251);
    repeat (3) @(negedge clk);
    reg_read(RA_STAT, v); chk("R8 masked completion not latched", v, 32'h2);
    chk("R9 irq low for bit without signal enable", 32'(irq), 32'h0);
    reg_write(RA_STAT, 32'hFF);
    reg_write(RA_STEN, 32'hFF);
    start_xfer(1'b1);
    for (int i = 0; i < 4; i++) push_byte(8'h61 + 8'(i));
    wait_evt(EV_RD_RDY, "R4 ready again");
    reg_read(RA_DATA, v);
    repeat (2) @(negedge clk);
    reg_read(RA_STAT, v); chk("R6 completion latched", v, 32'h6);
    chk("R9 irq high with signal enable", 32'(irq), 32'h1);
    reg_write(RA_STAT, 32'h4);
    repeat (2) @(negedge clk);
    chk("R9 irq drops after clear", 32'(irq), 32'h0);
    reg_write(RA_SIGEN, 32'h0);
    reg_write(RA_STAT, 32'hFF);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    tx_n = 0;
    reg_write(RA_PKT, 32'd0 | (32'd3 << 12));
    start_xfer(1'b0);
    reg_read(RA_STAT, v); chk("R6 size zero completes at once", v, 32'h4);
    reg_write(RA_STAT, 32'hFF);
    reg_write(RA_PKT, 32'd8);
    start_xfer(1'b1);
    reg_read(RA_STAT, v); chk("R6 count zero completes at once", v, 32'h4);
    chk("R6 no bytes requested", 32'(nand_rx_ready), 32'h0);
    chk("R6 no bytes sent", 32'(tx_n), 32'h0);
    reg_write(RA_STAT, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pkt_fields();
    t_read_xfer();
    t_round();
    t_write_xfer();
    t_masks();
    t_zero();
    summary();
  end
endmodule